// File: doc/BRIEF.md
# Gray-Coded Counter Clock-Domain Crossing

This block carries a free-running event counter from a slow source clock domain into a faster, unrelated destination clock domain. The counter is a binary register that steps by one on each source cycle in which an increment strobe is high. It wraps modulo 2^W. Its Gray-coded form is computed from the next binary value and captured in its own source-side flop. The word that crosses the boundary is therefore always a clean register output and never the output of XOR logic that can glitch while the binary bits ripple.

In the destination domain, every bit of the registered Gray word passes through a chain of synchronizer flops. The synchronized word is turned back into binary with an XOR prefix chain that runs from the top bit down, and the result is registered. The destination reads a counter value that lags the source by a few cycles, moves only forward, and only ever shows values that the source really held. A typical use is a pointer or event count observed by logic in another clock domain.

Top module: `gray_count_xfer`

## Requirements
- R1: `src_count` increases by exactly 1 (modulo 2^W) at each `src_clk` edge where `src_inc` is high and `src_rst` is low, and holds its value when `src_inc` is low.
- R2: While `src_rst` is high at a `src_clk` edge, `src_count` and `src_gray` become 0. While `dst_rst` is high at a `dst_clk` edge, `dst_count` becomes 0. Both resets are synchronous and active high.
- R3: `src_gray` always equals `src_count XOR (src_count >> 1)`, bit 0 being the least significant bit. It comes straight from a flop in the source domain.
- R4: Between two consecutive clock edges, `src_gray` changes in at most one bit position. The same holds for the synchronized Gray word seen in the destination.
- R5: When the source clock is slower than the destination clock, `dst_count` changes by 0 or +1 (modulo 2^W) from one `dst_clk` edge to the next. Every value it shows is one that `src_count` held, no more than 3 increments behind the current source value.
- R6: After the source stops incrementing, `dst_count` equals `src_count` within STAGES + 2 destination cycles, and it then stays constant while `src_inc` remains low.
- R7: The wrap from 2^W-1 to 0 reaches the destination as a single forward step, 2^W-1 followed by 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source domain clock |
| src_rst | input | 1 | Source synchronous reset, active high |
| src_inc | input | 1 | Increment strobe, sampled on `src_clk` |
| src_count | output | W | Registered binary counter, source domain |
| src_gray | output | W | Registered Gray form of `src_count`; the word that crosses domains |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst | input | 1 | Destination synchronous reset, active high |
| dst_count | output | W | Registered binary counter value, destination domain |

## Verification
On every clock cycle, the properties check the single-step behaviour of the source counter, the agreement between the Gray register and the binary register, the single-bit change of the Gray word on both sides of the boundary, and the 0-or-+1 step of the destination count. Several behaviours can only be shown by the bench's scenarios: the bounded lag between the two domains, convergence after the source goes quiet, stability while idle, and the wrap seen as one forward step. These depend on the real clock ratio and on a reference count kept outside the design, so the bench checks them with random strobe patterns, a long unbroken burst through the wrap point, and idle phases.

// File: rtl/gxc_pkg.sv
package gxc_pkg;
  // Minimum number of flops a crossing bit passes through in the receiving domain
  parameter int GXC_SYNC_DEPTH_DEFAULT = 2;
  // Default counter width
  parameter int GXC_WIDTH_DEFAULT = 8;
endpackage

// File: rtl/gxc_src_counter.sv
module gxc_src_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count_o,
  output logic [W-1:0] gray_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_nxt;
  logic [W-1:0] gray_q;
  logic [W-1:0] gray_nxt;

  assign cnt_nxt = cnt_q + W'(inc);

  // Gray form of the next value; each bit is the XOR of two neighbouring binary bits
  assign gray_nxt[W-1] = cnt_nxt[W-1];
  for (genvar i = 0; i < W-1; i++) begin : g_enc
    assign gray_nxt[i] = cnt_nxt[i] ^ cnt_nxt[i+1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      gray_q <= '0;
    end else begin
      cnt_q  <= cnt_nxt;
      gray_q <= gray_nxt;
    end
  end

  assign count_o = cnt_q;
  assign gray_o  = gray_q;

  // R1
  src_step_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(inc) && !$past(rst)) |-> (cnt_q == W'($past(cnt_q) + 1'b1)));
  // R1
  src_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(inc) && !$past(rst)) |-> $stable(cnt_q));
  // R3
  src_gray_match_chk: assert property (@(posedge clk) disable iff (rst)
    gray_q == (cnt_q ^ (cnt_q >> 1)));
  // R4
  src_gray_onebit_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($countones(gray_q ^ $past(gray_q)) <= 1));
endmodule

// File: rtl/gxc_sync.sv
module gxc_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gxc_gray_decode.sv
module gxc_gray_decode #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] bin_c;
  logic [W-1:0] bin_q;

  // Prefix XOR from the top bit downward
  assign bin_c[W-1] = gray_i[W-1];
  for (genvar i = W-2; i >= 0; i--) begin : g_dec
    assign bin_c[i] = bin_c[i+1] ^ gray_i[i];
  end

  always_ff @(posedge clk) begin
    if (rst) bin_q <= '0;
    else     bin_q <= bin_c;
  end

  assign bin_o = bin_q;

  // R4
  dst_gray_onebit_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($countones(gray_i ^ $past(gray_i)) <= 1));
  // R5
  dst_fwd_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (W'(bin_q - $past(bin_q)) <= W'(1)));
endmodule

// File: rtl/gray_count_xfer.sv
module gray_count_xfer
  import gxc_pkg::*;
#(
  parameter int W      = GXC_WIDTH_DEFAULT,
  parameter int STAGES = GXC_SYNC_DEPTH_DEFAULT
) (
  input  logic         src_clk,
  input  logic         src_rst,
  input  logic         src_inc,
  output logic [W-1:0] src_count,
  output logic [W-1:0] src_gray,
  input  logic         dst_clk,
  input  logic         dst_rst,
  output logic [W-1:0] dst_count
);
  localparam int SYNC_DEPTH = (STAGES < GXC_SYNC_DEPTH_DEFAULT) ? GXC_SYNC_DEPTH_DEFAULT : STAGES;

  logic [W-1:0] gray_sync;

  gxc_src_counter #(.W(W)) u_src (
    .clk     (src_clk),
    .rst     (src_rst),
    .inc     (src_inc),
    .count_o (src_count),
    .gray_o  (src_gray)
  );

  gxc_sync #(.W(W), .STAGES(SYNC_DEPTH)) u_sync (
    .clk (dst_clk),
    .rst (dst_rst),
    .d_i (src_gray),
    .q_o (gray_sync)
  );

  gxc_gray_decode #(.W(W)) u_dec (
    .clk    (dst_clk),
    .rst    (dst_rst),
    .gray_i (gray_sync),
    .bin_o  (dst_count)
  );

  // R2
  dst_reset_zero_chk: assert property (@(posedge dst_clk)
    $past(dst_rst) |-> (dst_count == '0));
endmodule

// File: tb/gray_count_xfer_tb.sv
module gray_count_xfer_tb;
  localparam int W = 8;
  localparam int M = 1 << W;

  logic src_clk = 1'b0;
  logic dst_clk = 1'b0;
  logic src_rst = 1'b1;
  logic dst_rst = 1'b1;
  logic src_inc = 1'b0;
  logic [W-1:0] src_count, src_gray, dst_count;

  int checks = 0;
  int fails  = 0;
  int exp_src = 0;
  bit mon_en = 1'b0;
  int prev_dst = 0;
  bit saw_wrap = 1'b0;
  bit done = 1'b0;

  always #10 src_clk = ~src_clk;  // slow source
  always #4  dst_clk = ~dst_clk;  // 125 MHz destination

  gray_count_xfer #(.W(W), .STAGES(2)) u_dut (
    .src_clk(src_clk), .src_rst(src_rst), .src_inc(src_inc),
    .src_count(src_count), .src_gray(src_gray),
    .dst_clk(dst_clk), .dst_rst(dst_rst), .dst_count(dst_count)
  );

  function automatic int to_gray(int v);
    return (v ^ (v >> 1)) % M;
  endfunction

  function automatic int fwd_dist(int from, int to);
    return ((to - from) % M + M) % M;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model of the source counter
  always @(posedge src_clk) begin
    if (src_rst) exp_src <= 0;
    else if (src_inc) exp_src <= (exp_src + 1) % M;
  end

  // Source-side checks, away from the active edge
  always @(negedge src_clk) begin
    if (!src_rst) begin
      chk(int'(src_count) == exp_src, "R1 count", int'(src_count), exp_src);
      chk(int'(src_gray) == to_gray(int'(src_count)), "R3 gray", int'(src_gray), to_gray(int'(src_count)));
    end
  end

  // Destination monitor
  always @(negedge dst_clk) begin
    if (mon_en) begin
      chk(fwd_dist(prev_dst, int'(dst_count)) <= 1, "R5 step", int'(dst_count), prev_dst);
      chk(fwd_dist(int'(dst_count), exp_src) <= 3, "R5 lag", int'(dst_count), exp_src);
      if (prev_dst == M-1 && dst_count == 0) saw_wrap = 1'b1;
    end
    prev_dst = int'(dst_count);
  end

  task automatic run_src(int n, int pct);
    for (int i = 0; i < n; i++) begin
      @(negedge src_clk);
      src_inc = (($urandom % 100) < pct);
    end
  endtask

  task automatic settle_and_check(string tag);
    @(negedge src_clk);
    src_inc = 1'b0;
    repeat (2) @(negedge src_clk);
    repeat (4) @(negedge dst_clk);  // STAGES + 2 destination cycles
    chk(int'(dst_count) == exp_src, "R6 converge", int'(dst_count), exp_src);
    for (int k = 0; k < 10; k++) begin
      @(negedge dst_clk);
      chk(int'(dst_count) == exp_src, "R6 idle hold", int'(dst_count), exp_src);
    end
    if (tag.len() == 0) checks = checks;
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (5) @(negedge src_clk);
    chk(src_count == 0, "R2 src reset", int'(src_count), 0);
    chk(src_gray == 0, "R2 gray reset", int'(src_gray), 0);
    chk(dst_count == 0, "R2 dst reset", int'(dst_count), 0);
    src_rst = 1'b0;
    dst_rst = 1'b0;
    repeat (2) @(negedge dst_clk);
    mon_en = 1'b1;

    // Directed: single increment then idle
    @(negedge src_clk); src_inc = 1'b1;
    @(negedge src_clk); src_inc = 1'b0;
    settle_and_check("single");

    // Random densities
    run_src(600, 30);
    settle_and_check("sparse");
    run_src(600, 80);
    settle_and_check("dense");

    // Directed unbroken burst through the wrap point (R7)
    saw_wrap = 1'b0;
    run_src(M + 20, 100);
    settle_and_check("burst");
    chk(saw_wrap, "R7 wrap seen", int'(saw_wrap), 1);

    run_src(1000, 50);
    settle_and_check("mixed");

    // Reset again with both domains held
    mon_en = 1'b0;
    src_rst = 1'b1;
    dst_rst = 1'b1;
    repeat (4) @(negedge src_clk);
    chk(src_count == 0, "R2 src re-reset", int'(src_count), 0);
    chk(src_gray == 0, "R2 gray re-reset", int'(src_gray), 0);
    chk(dst_count == 0, "R2 dst re-reset", int'(dst_count), 0);
    src_rst = 1'b0;
    dst_rst = 1'b0;
    repeat (2) @(negedge dst_clk);
    mon_en = 1'b1;
    run_src(100, 60);
    settle_and_check("post");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule